// File: doc/BRIEF.md
# Serial Channel Command and Status Core

This block is the control core for one asynchronous serial channel of a two-channel UART. A processor reaches it over a byte-wide register bus. It turns bus writes into register updates and command effects, and it turns bus reads into register contents and status. The bit-level shift engines, the baud generator and any receive queue sit outside the block. They reach it through simple handshakes: a receive push carrying one character with its error flags, and a transmit start pulse that is held off by a busy input.

Writes to the command register enable, disable and reset each direction. They can also rewind the mode-register pointer and switch a line break on or off. Two mode registers share one address: an access pointer starts at the first register and moves to the second after the first access. The status byte reports receive and transmit readiness, transmitter emptiness, and the error flags of the held character. The parameter `CHAN_IDX` places the channel's 32-byte window in the address space, so two instances share one bus.

Top module: `sercmd_channel`

## Requirements
- R1: The channel answers only inside its window, which starts at `CHAN_IDX` times 0x20. At window offset 0x00 are the mode registers. Offset 0x04 is status on read and clock select on write. Offset 0x08 is the write-only command register. Offset 0x0C is the receive character on read and the transmit character on write. Every other address has no effect and reads as 0x00, and so does a read of offset 0x08.
- R2: After reset, or after a pointer-rewind command, the first access (read or write) at offset 0x00 reaches mode register 1. Every later access reaches mode register 2 until the next rewind.
- R3: Command bits 6:4 select one action: 1 rewinds the mode pointer, 2 resets the receiver, 3 resets the transmitter, 6 starts a break, 7 stops a break. The values 0, 4 and 5 do nothing, and bit 7 is ignored.
- R4: Command bit 0 enables the receiver and bit 1 disables it. Bit 2 enables the transmitter and bit 3 disables it. A direction with neither bit set keeps its state, and with both bits set it ends up disabled. These bits are applied after the action of the same write, so a reset and an enable in one write leave that direction enabled.
- R5: The status byte holds receiver ready at bit 0, transmitter ready at bit 2, transmitter empty at bit 3, overrun at bit 4, parity error at bit 5, framing error at bit 6 and received break at bit 7. Bit 1 reads 0.
- R6: A receive push while the receiver is enabled and empty stores the character and sets receiver ready. Its parity, framing and break flags go to status bits 5, 6 and 7. A push while the receiver is disabled is discarded.
- R7: A push while a character is already held keeps the held character and sets the overrun flag. Overrun clears only on a receiver reset.
- R8: Reading offset 0x0C returns the held character. At that clock edge it clears receiver ready and status bits 5 to 7. If a push lands in the same cycle as the read, the new character is stored and receiver ready stays set.
- R9: A receiver reset clears receiver ready, all four error flags and the receiver enable. A push in the cycle of the reset write is discarded.
- R10: Transmitter ready means the transmitter is enabled, the holding register is empty and no break is active. A character write is accepted only while transmitter ready is set. A held character raises `tx_start` for exactly one cycle, with the byte on `tx_byte`, as soon as `tx_busy` is low. Transmitter empty means transmitter ready with `tx_busy` low.
- R11: A transmitter reset discards the held character and disables the transmitter. Transmitter ready stays low and no start occurs until the transmitter is enabled again.
- R12: While a break is active, `tx_force_low` is high, transmitter ready is low and no start pulse occurs. A stop-break command releases all three.
- R13: Reset clears the mode registers, the clock select, both enables, the break and all status flags. A write at offset 0x04 sets `clk_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address on the register bus |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle, 0x00 otherwise |
| rx_push | input | 1 | Receive engine delivers a character |
| rx_char | input | 8 | Delivered character |
| rx_perr | input | 1 | Parity error on the delivered character |
| rx_ferr | input | 1 | Framing error on the delivered character |
| rx_brk | input | 1 | Delivered character is a break |
| tx_busy | input | 1 | Transmit engine is shifting |
| tx_start | output | 1 | One-cycle start request to the transmit engine |
| tx_byte | output | 8 | Character to send, valid with tx_start |
| tx_force_low | output | 1 | Hold the serial output low (break) |
| rx_enabled | output | 1 | Receiver enable state |
| tx_enabled | output | 1 | Transmitter enable state |
| mode1 | output | 8 | Mode register 1 contents |
| mode2 | output | 8 | Mode register 2 contents |
| clk_sel | output | 8 | Clock-select contents |

## Verification
The two functions that meet in one cycle are a processor read of the receive character and a push from the receive engine. The bench provokes this by raising `rx_push` in the same cycle as the read strobe at offset 0x0C. The read must return the old character, receiver ready must stay set, and the following read must return the new character with no overrun flagged. A command write also meets the receive path in one cycle: a push during a receiver-reset write must leave status at zero. Command decoding is swept over all 128 values of bits 6:0, starting from both enable states, with the expected enables, break and pointer position worked out from R3 and R4.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int DATA_W = 8;

    // Status byte bit positions (software decodes these)
    localparam int ST_RXRDY = 0;
    localparam int ST_TXRDY = 2;
    localparam int ST_TXEMT = 3;
    localparam int ST_OVR   = 4;
    localparam int ST_PAR   = 5;
    localparam int ST_FRM   = 6;
    localparam int ST_BRK   = 7;

    typedef enum logic [1:0] {
        REG_MODE      = 2'd0,
        REG_STAT_CSEL = 2'd1,
        REG_CMD       = 2'd2,
        REG_HOLD      = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_PTR_RST = 3'd1,
        ACT_RX_RST  = 3'd2,
        ACT_TX_RST  = 3'd3,
        ACT_RSV4    = 3'd4,
        ACT_RSV5    = 3'd5,
        ACT_BRK_ON  = 3'd6,
        ACT_BRK_OFF = 3'd7
    } cmd_act_e;

    typedef struct packed {
        logic mode_acc;
        logic mode_wr;
        logic csel_wr;
        logic hold_wr;
        logic hold_rd;
    } bus_strobe_t;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_on;
        logic brk_off;
        logic rx_en;
        logic rx_dis;
        logic tx_en;
        logic tx_dis;
    } cmd_pulse_t;

endpackage

// File: rtl/sercmd_decode.sv
module sercmd_decode
    import sercmd_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int WIN_BITS = 5,
    parameter int CHAN_IDX = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [6:0]        cmd_bits,
    output logic              hit,
    output reg_sel_e          sel,
    output bus_strobe_t       strb,
    output cmd_pulse_t        cmd
);

    localparam int CH_W = ADDR_W - WIN_BITS;

    logic [CH_W-1:0]     chan_field;
    logic [WIN_BITS-1:0] offs;
    cmd_act_e            act;
    logic                cmd_wr;

    always_comb begin
        chan_field = addr[ADDR_W-1:WIN_BITS];
        offs       = addr[WIN_BITS-1:0];
        hit        = (chan_field == CH_W'(CHAN_IDX))
                  && ((offs >> 4) == '0)
                  && (offs[1:0] == 2'b00);
        sel        = reg_sel_e'(offs[3:2]);
        act        = cmd_act_e'(cmd_bits[6:4]);
        cmd_wr     = hit && wr && (sel == REG_CMD);

        strb = '0;
        if (hit) begin
            strb.mode_acc = (wr || rd) && (sel == REG_MODE);
            strb.mode_wr  = wr && (sel == REG_MODE);
            strb.csel_wr  = wr && (sel == REG_STAT_CSEL);
            strb.hold_wr  = wr && (sel == REG_HOLD);
            strb.hold_rd  = rd && !wr && (sel == REG_HOLD);
        end

        cmd = '0;
        if (cmd_wr) begin
            unique case (act)
                ACT_PTR_RST: cmd.ptr_rst = 1'b1;
                ACT_RX_RST:  cmd.rx_rst  = 1'b1;
                ACT_TX_RST:  cmd.tx_rst  = 1'b1;
                ACT_BRK_ON:  cmd.brk_on  = 1'b1;
                ACT_BRK_OFF: cmd.brk_off = 1'b1;
                default:     ;
            endcase
            cmd.rx_en  = cmd_bits[0];
            cmd.rx_dis = cmd_bits[1];
            cmd.tx_en  = cmd_bits[2];
            cmd.tx_dis = cmd_bits[3];
        end
    end

endmodule

// File: rtl/sercmd_mode.sv
module sercmd_mode
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              wr,
    input  logic              csel_wr,
    input  logic              ptr_rst,
    input  logic [DATA_W-1:0] wdata,
    output logic              at_mr2,
    output logic [DATA_W-1:0] mr1,
    output logic [DATA_W-1:0] mr2,
    output logic [DATA_W-1:0] csel
);

    typedef struct packed {
        logic              at_mr2;
        logic [DATA_W-1:0] mr1;
        logic [DATA_W-1:0] mr2;
        logic [DATA_W-1:0] csel;
    } mode_state_t;

    mode_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ptr_rst) begin
            s_d.at_mr2 = 1'b0;
        end else if (acc) begin
            if (wr) begin
                if (s_q.at_mr2) s_d.mr2 = wdata;
                else            s_d.mr1 = wdata;
            end
            s_d.at_mr2 = 1'b1;
        end
        if (csel_wr) s_d.csel = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign at_mr2 = s_q.at_mr2;
    assign mr1    = s_q.mr1;
    assign mr2    = s_q.mr2;
    assign csel   = s_q.csel;

    AST_PTR_STAYS_AT_MR2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.at_mr2 && !ptr_rst) |=> s_q.at_mr2); // R2
    AST_MR1_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.at_mr2 && !ptr_rst) |=> $stable(s_q.mr1)); // R2
    AST_PTR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> !s_q.at_mr2); // R3

endmodule

// File: rtl/sercmd_rx.sv
module sercmd_rx
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] char_in,
    input  logic              perr,
    input  logic              ferr,
    input  logic              brk,
    input  logic              hold_rd,
    input  logic              rx_rst,
    input  logic              en_cmd,
    input  logic              dis_cmd,
    output logic              enabled,
    output logic              rdy,
    output logic              ovr,
    output logic              par,
    output logic              frm,
    output logic              brk_flag,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              en;
        logic              full;
        logic              ovr;
        logic              par;
        logic              frm;
        logic              brk;
        logic [DATA_W-1:0] data;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic      accept;

    always_comb begin
        s_d    = s_q;
        accept = push && s_q.en && !rx_rst;

        if (rx_rst) begin
            s_d.en   = 1'b0;
            s_d.full = 1'b0;
            s_d.ovr  = 1'b0;
            s_d.par  = 1'b0;
            s_d.frm  = 1'b0;
            s_d.brk  = 1'b0;
        end

        if (dis_cmd)     s_d.en = 1'b0;
        else if (en_cmd) s_d.en = 1'b1;

        if (hold_rd) begin
            s_d.full = 1'b0;
            s_d.par  = 1'b0;
            s_d.frm  = 1'b0;
            s_d.brk  = 1'b0;
        end

        if (accept) begin
            if (s_q.full && !hold_rd) begin
                s_d.ovr = 1'b1;
            end else begin
                s_d.full = 1'b1;
                s_d.data = char_in;
                s_d.par  = perr;
                s_d.frm  = ferr;
                s_d.brk  = brk;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign enabled  = s_q.en;
    assign rdy      = s_q.full;
    assign ovr      = s_q.ovr;
    assign par      = s_q.par;
    assign frm      = s_q.frm;
    assign brk_flag = s_q.brk;
    assign data     = s_q.data;

    AST_RX_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !s_q.en && !s_q.full) |=> !s_q.full); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovr && !rx_rst) |=> s_q.ovr); // R7
    AST_OVR_KEEPS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && !hold_rd && !rx_rst) |=> ($stable(s_q.data) && s_q.full)); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_rd && !push) |=> (!s_q.full && !s_q.par && !s_q.frm && !s_q.brk)); // R8
    AST_RX_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |=> (!s_q.full && !s_q.ovr && !s_q.par && !s_q.frm && !s_q.brk)); // R9

endmodule

// File: rtl/sercmd_tx.sv
module sercmd_tx
    import sercmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              tx_rst,
    input  logic              en_cmd,
    input  logic              dis_cmd,
    input  logic              brk_on,
    input  logic              brk_off,
    output logic              enabled,
    output logic              txrdy,
    output logic              txemt,
    output logic              start,
    output logic [DATA_W-1:0] byte_out,
    output logic              force_low
);

    typedef struct packed {
        logic              en;
        logic              full;
        logic              brk;
        logic [DATA_W-1:0] hold;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        txrdy    = s_q.en && !s_q.full && !s_q.brk;
        txemt    = txrdy && !busy;
        start    = s_q.en && s_q.full && !s_q.brk && !busy;
        byte_out = s_q.hold;

        s_d = s_q;
        if (tx_rst) begin
            s_d.en   = 1'b0;
            s_d.full = 1'b0;
        end
        if (brk_on)       s_d.brk = 1'b1;
        else if (brk_off) s_d.brk = 1'b0;

        if (dis_cmd)     s_d.en = 1'b0;
        else if (en_cmd) s_d.en = 1'b1;

        if (start) s_d.full = 1'b0;
        if (hold_wr && txrdy) begin
            s_d.full = 1'b1;
            s_d.hold = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign enabled   = s_q.en;
    assign force_low = s_q.brk;

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R10
    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && !start && !tx_rst) |=> (s_q.full && $stable(s_q.hold))); // R10
    AST_TXRST_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rst && !en_cmd) |=> (!txrdy && !start)); // R11
    AST_BREAK_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        brk_on |=> (force_low && !txrdy && !start)); // R12

endmodule

// File: rtl/sercmd_channel.sv
module sercmd_channel
    import sercmd_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int WIN_BITS = 5,
    parameter int CHAN_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_push,
    input  logic [7:0]        rx_char,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              tx_busy,
    output logic              tx_start,
    output logic [7:0]        tx_byte,
    output logic              tx_force_low,
    output logic              rx_enabled,
    output logic              tx_enabled,
    output logic [7:0]        mode1,
    output logic [7:0]        mode2,
    output logic [7:0]        clk_sel
);

    logic        hit;
    reg_sel_e    sel;
    bus_strobe_t strb;
    cmd_pulse_t  cmd;

    logic              at_mr2;
    logic              rx_rdy, rx_ovr, rx_par, rx_frm, rx_brkf;
    logic [DATA_W-1:0] rx_data;
    logic              txrdy, txemt;
    logic [DATA_W-1:0] status;

    sercmd_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .CHAN_IDX (CHAN_IDX)
    ) u_decode (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .cmd_bits (bus_wdata[6:0]),
        .hit      (hit),
        .sel      (sel),
        .strb     (strb),
        .cmd      (cmd)
    );

    sercmd_mode u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (strb.mode_acc),
        .wr      (strb.mode_wr),
        .csel_wr (strb.csel_wr),
        .ptr_rst (cmd.ptr_rst),
        .wdata   (bus_wdata),
        .at_mr2  (at_mr2),
        .mr1     (mode1),
        .mr2     (mode2),
        .csel    (clk_sel)
    );

    sercmd_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_push),
        .char_in  (rx_char),
        .perr     (rx_perr),
        .ferr     (rx_ferr),
        .brk      (rx_brk),
        .hold_rd  (strb.hold_rd),
        .rx_rst   (cmd.rx_rst),
        .en_cmd   (cmd.rx_en),
        .dis_cmd  (cmd.rx_dis),
        .enabled  (rx_enabled),
        .rdy      (rx_rdy),
        .ovr      (rx_ovr),
        .par      (rx_par),
        .frm      (rx_frm),
        .brk_flag (rx_brkf),
        .data     (rx_data)
    );

    sercmd_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_wr   (strb.hold_wr),
        .wdata     (bus_wdata),
        .busy      (tx_busy),
        .tx_rst    (cmd.tx_rst),
        .en_cmd    (cmd.tx_en),
        .dis_cmd   (cmd.tx_dis),
        .brk_on    (cmd.brk_on),
        .brk_off   (cmd.brk_off),
        .enabled   (tx_enabled),
        .txrdy     (txrdy),
        .txemt     (txemt),
        .start     (tx_start),
        .byte_out  (tx_byte),
        .force_low (tx_force_low)
    );

    always_comb begin
        status           = '0;
        status[ST_RXRDY] = rx_rdy;
        status[ST_TXRDY] = txrdy;
        status[ST_TXEMT] = txemt;
        status[ST_OVR]   = rx_ovr;
        status[ST_PAR]   = rx_par;
        status[ST_FRM]   = rx_frm;
        status[ST_BRK]   = rx_brkf;

        bus_rdata = '0;
        if (hit && bus_rd && !bus_wr) begin
            unique case (sel)
                REG_MODE:      bus_rdata = at_mr2 ? mode2 : mode1;
                REG_STAT_CSEL: bus_rdata = status;
                REG_CMD:       bus_rdata = '0;
                REG_HOLD:      bus_rdata = rx_data;
                default:       bus_rdata = '0;
            endcase
        end
    end

    AST_EMPTY_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (txemt && !tx_busy) |-> !tx_start); // R10

endmodule

// File: tb/tb_sercmd_channel.sv
module tb_sercmd_channel;

    localparam logic [5:0] BASE = 6'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_push = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_perr = 1'b0;
    logic       rx_ferr = 1'b0;
    logic       rx_brk = 1'b0;
    logic       tx_busy = 1'b0;
    logic       tx_start;
    logic [7:0] tx_byte;
    logic       tx_force_low;
    logic       rx_enabled;
    logic       tx_enabled;
    logic [7:0] mode1, mode2, clk_sel;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    logic [7:0] last_tx = '0;

    sercmd_channel #(.CHAN_IDX(1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_push(rx_push), .rx_char(rx_char), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .tx_busy(tx_busy),
        .tx_start(tx_start), .tx_byte(tx_byte), .tx_force_low(tx_force_low),
        .rx_enabled(rx_enabled), .tx_enabled(tx_enabled),
        .mode1(mode1), .mode2(mode2), .clk_sel(clk_sel)
    );

    always #2ns clk = ~clk;

    always @(posedge clk) begin
        if (rst_n && tx_start) begin
            starts  = starts + 1;
            last_tx = tx_byte;
        end
    end

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1ns d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_char(input logic [7:0] c, input logic [2:0] f);
        @(negedge clk);
        rx_push = 1'b1; rx_char = c; {rx_brk, rx_ferr, rx_perr} = f;
        @(negedge clk);
        rx_push = 1'b0; {rx_brk, rx_ferr, rx_perr} = 3'b000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tx_busy = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] exp_csel;
        do_reset();

        // R13 reset state
        chk("R13 mode1", mode1, 8'h00);
        chk("R13 mode2", mode2, 8'h00);
        chk("R13 clk_sel", clk_sel, 8'h00);
        chk("R13 enables", {6'b0, rx_enabled, tx_enabled}, 8'h00);
        chk("R13 break", {7'b0, tx_force_low}, 8'h00);
        rd_reg(BASE + 6'h04, r);
        chk("R13 status", r, 8'h00);

        // R1 write sweep over every address
        exp_csel = 8'h00;
        for (int a = 0; a < 64; a++) begin
            logic [7:0] d;
            d = 8'h80 | 8'(a);
            wr_reg(6'(a), d);
            if (6'(a) == BASE + 6'h04) exp_csel = d;
            chk("R1 clk_sel decode", clk_sel, exp_csel);
        end
        chk("R1 mode1 decode", mode1, 8'hA0);
        chk("R1 mode2 decode", mode2, 8'h00);

        // R1 read sweep: unmapped and command addresses read zero
        for (int a = 0; a < 64; a++) begin
            if (6'(a) != BASE && 6'(a) != BASE + 6'h04 && 6'(a) != BASE + 6'h0C) begin
                rd_reg(6'(a), r);
                chk("R1 read zero", r, 8'h00);
            end
        end

        // R2 mode pointer sequencing
        do_reset();
        wr_reg(BASE, 8'h11);
        chk("R2 first to mode1", mode1, 8'h11);
        wr_reg(BASE, 8'h22);
        chk("R2 second to mode2", mode2, 8'h22);
        wr_reg(BASE, 8'h33);
        chk("R2 stays at mode2", mode2, 8'h33);
        chk("R2 mode1 kept", mode1, 8'h11);
        rd_reg(BASE, r);
        chk("R2 read mode2", r, 8'h33);
        wr_reg(BASE + 6'h08, 8'h10);
        rd_reg(BASE, r);
        chk("R2 rewind read mode1", r, 8'h11);
        rd_reg(BASE, r);
        chk("R2 after read mode2", r, 8'h33);
        wr_reg(BASE + 6'h08, 8'h10);
        wr_reg(BASE, 8'h44);
        chk("R2 rewind write mode1", mode1, 8'h44);
        wr_reg(BASE + 6'h08, 8'h10);
        wr_reg(BASE, 8'h11);
        wr_reg(BASE, 8'h22);

        // R3/R4 exhaustive command sweep from both enable states
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 128; v++) begin
                logic [2:0] act;
                logic erx, etx, ebrk;
                wr_reg(BASE + 6'h08, 8'h70);
                wr_reg(BASE + 6'h08, 8'h20);
                wr_reg(BASE + 6'h08, 8'h30);
                wr_reg(BASE + 6'h08, (s != 0) ? 8'h05 : 8'h00);
                rd_reg(BASE, r);
                if (s != 0) push_char(8'h5A, 3'b000);
                wr_reg(BASE + 6'h08, {v[0], 7'(v)});
                act  = 3'(v >> 4);
                erx  = (s != 0) && (act != 3'd2);
                etx  = (s != 0) && (act != 3'd3);
                if (v[1])      erx = 1'b0;
                else if (v[0]) erx = 1'b1;
                if (v[3])      etx = 1'b0;
                else if (v[2]) etx = 1'b1;
                ebrk = (act == 3'd6);
                chk("R4 rx enable", {7'b0, rx_enabled}, {7'b0, erx});
                chk("R3 break", {7'b0, tx_force_low}, {7'b0, ebrk});
                rd_reg(BASE + 6'h04, r);
                chk("R3 R4 status", {r[2], r[0]},
                    {etx && !ebrk, (s != 0) && (act != 3'd2)});
                rd_reg(BASE, r);
                chk("R3 pointer", r, (act == 3'd1) ? 8'h11 : 8'h22);
            end
        end

        // R5/R6 status layout over all flag combinations
        do_reset();
        wr_reg(BASE + 6'h08, 8'h05);
        rd_reg(BASE + 6'h04, r);
        chk("R5 tx idle ready and empty", r, 8'h0C);
        for (int f = 0; f < 8; f++) begin
            push_char(8'h30 + 8'(f), 3'(f));
            rd_reg(BASE + 6'h04, r);
            chk("R5 R6 status flags", r, {3'(f), 5'b01101});
            rd_reg(BASE + 6'h0C, r);
            chk("R8 char", r, 8'h30 + 8'(f));
            rd_reg(BASE + 6'h04, r);
            chk("R8 cleared", r, 8'h0C);
        end

        // R7 overrun
        push_char(8'hA1, 3'b001);
        push_char(8'hB2, 3'b110);
        rd_reg(BASE + 6'h04, r);
        chk("R7 overrun set", r, 8'h3D);
        rd_reg(BASE + 6'h0C, r);
        chk("R7 old char kept", r, 8'hA1);
        rd_reg(BASE + 6'h04, r);
        chk("R7 overrun sticky", r, 8'h1C);

        // R9 receiver reset, push in same cycle discarded
        @(negedge clk);
        bus_addr = BASE + 6'h08; bus_wdata = 8'h20; bus_wr = 1'b1;
        rx_push = 1'b1; rx_char = 8'hC3;
        @(negedge clk);
        bus_wr = 1'b0; rx_push = 1'b0;
        rd_reg(BASE + 6'h04, r);
        chk("R9 reset clears", r, 8'h0C);
        chk("R9 disabled", {7'b0, rx_enabled}, 8'h00);

        // R6 disabled receiver ignores push
        push_char(8'h77, 3'b111);
        rd_reg(BASE + 6'h04, r);
        chk("R6 disabled push ignored", r, 8'h0C);

        // R8 read and push in the same cycle
        wr_reg(BASE + 6'h08, 8'h01);
        push_char(8'h61, 3'b000);
        @(negedge clk);
        bus_addr = BASE + 6'h0C; bus_rd = 1'b1;
        rx_push = 1'b1; rx_char = 8'h62; rx_perr = 1'b1;
        #1ns r = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; rx_push = 1'b0; rx_perr = 1'b0;
        chk("R8 collide old char", r, 8'h61);
        rd_reg(BASE + 6'h04, r);
        chk("R8 collide status", r, 8'h2D);
        rd_reg(BASE + 6'h0C, r);
        chk("R8 collide new char", r, 8'h62);

        // R10 transmit path
        do_reset();
        wr_reg(BASE + 6'h08, 8'h04);
        @(negedge clk) tx_busy = 1'b1;
        wr_reg(BASE + 6'h0C, 8'h81);
        rd_reg(BASE + 6'h04, r);
        chk("R10 held not ready", r, 8'h00);
        wr_reg(BASE + 6'h0C, 8'h99);
        chk("R10 no start while busy", 8'(starts), 8'd0);
        @(negedge clk) tx_busy = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 one start", 8'(starts), 8'd1);
        chk("R10 byte", last_tx, 8'h81);
        rd_reg(BASE + 6'h04, r);
        chk("R10 ready again", r, 8'h0C);
        wr_reg(BASE + 6'h0C, 8'h42);
        repeat (2) @(negedge clk);
        chk("R10 second start", 8'(starts), 8'd2);
        chk("R10 second byte", last_tx, 8'h42);

        // R12 break
        wr_reg(BASE + 6'h08, 8'h60);
        chk("R12 force low", {7'b0, tx_force_low}, 8'h01);
        rd_reg(BASE + 6'h04, r);
        chk("R12 not ready", r, 8'h00);
        wr_reg(BASE + 6'h0C, 8'h13);
        repeat (2) @(negedge clk);
        chk("R12 no start", 8'(starts), 8'd2);
        wr_reg(BASE + 6'h08, 8'h70);
        chk("R12 released", {7'b0, tx_force_low}, 8'h00);
        rd_reg(BASE + 6'h04, r);
        chk("R12 ready after stop", r, 8'h0C);

        // R11 transmitter reset
        @(negedge clk) tx_busy = 1'b1;
        wr_reg(BASE + 6'h0C, 8'h55);
        wr_reg(BASE + 6'h08, 8'h30);
        @(negedge clk) tx_busy = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 discarded", 8'(starts), 8'd2);
        rd_reg(BASE + 6'h04, r);
        chk("R11 not ready", r, 8'h00);
        wr_reg(BASE + 6'h08, 8'h04);
        rd_reg(BASE + 6'h04, r);
        chk("R11 ready after enable", r, 8'h0C);
        chk("R11 still no start", 8'(starts), 8'd2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule